// File: doc/BRIEF.md
# Multiprocessor-Capable Start-Stop Serial Transceiver

This block is a full-duplex asynchronous serial transceiver. Its transmit and receive halves run independently, and each half has a one-character holding stage in front of its shift register, so characters can follow each other with no idle gap on the line. Bit timing comes from an enable pulse supplied from outside, running at sixteen pulses per bit. Software picks the character format from a small set of static controls: 7 or 8 data bits, one or two stop bits, even, odd or no parity, and an optional address-marker bit.

When the address marker is enabled, it replaces the parity bit. A value of 1 marks the character as a station ID and 0 marks it as payload. A receiver can be put into a wait state in which payload characters are thrown away silently. The first ID character ends the wait. The receiver flags parity, framing and overrun errors. It also exposes the synchronised level of the receive line, so software can recognise a break after a framing error.

Top module: `mpx_uart`

## Requirements
- R1: After reset, txd is 1, tx_hold_empty is 1, rx_valid, err_parity, err_frame, err_overrun and mp_wait are 0, and rxd_level is 1.
- R2: A transmitted character is, in time order: a 0 start bit, the data bits LSB first (7 when cfg_len7=1, else 8), the extra bit if any, then one stop bit of 1 (two when cfg_stop2=1). Each bit lasts 16 tick pulses, and the line is 1 between characters.
- R3: The extra bit is the address marker (tx_mpb) when cfg_mp_en=1. Otherwise it is a parity bit when cfg_par is 1 (even: total ones over data and parity is even) or 2 (odd: total is odd). cfg_par values 0 and 3 send no extra bit.
- R4: A tx_wr pulse is accepted only while tx_hold_empty=1, and a write while it is 0 is dropped. A character already waiting when the current one ends starts with no idle gap.
- R5: The receiver confirms a start bit when the line is still 0 eight ticks after it was first seen low. It samples each later bit 16 ticks apart, presents the character on rx_data with rx_valid=1, and rx_rd clears rx_valid. A low pulse that is gone at the confirmation point produces no character.
- R6: When parity is in use and the received extra bit does not match the parity of the data, err_parity is set along with the character.
- R7: A 0 in the first stop bit sets err_frame. rxd_level follows the receive line through a two-register synchroniser, so it reads 0 while the line is held low.
- R8: If a character completes while rx_valid=1 and no rx_rd comes in that cycle, err_overrun is set and the new character is dropped, so rx_data keeps the unread one.
- R9: A mp_wait_set pulse sets mp_wait. With cfg_mp_en=1 and mp_wait=1, a character whose marker is 0 changes neither rx_valid nor any error flag. A character whose marker is 1 is delivered with rx_mpb=1 and clears mp_wait.
- R10: In 7-bit format, rx_data[7] is 0.
- R11: An err_clr pulse clears err_parity, err_frame and err_overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Oversampling enable, 16 per bit |
| cfg_len7 | input | 1 | 1 selects 7 data bits |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| cfg_par | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_mp_en | input | 1 | Address-marker bit replaces parity |
| tx_wr | input | 1 | Write pulse into the transmit holding stage |
| tx_data | input | 8 | Character to send |
| tx_mpb | input | 1 | Marker value sent with the character |
| tx_hold_empty | output | 1 | Transmit holding stage can take a character |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rxd_level | output | 1 | Synchronised receive line level |
| rx_data | output | 8 | Last received character |
| rx_mpb | output | 1 | Marker bit of that character |
| rx_valid | output | 1 | Unread character present |
| rx_rd | input | 1 | Read pulse, clears rx_valid |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |
| err_clr | input | 1 | Clears the three error flags |
| mp_wait_set | input | 1 | Enters the ID-wait state |
| mp_wait | output | 1 | ID-wait state active |

## Verification
The transmit line is compared every clock against a behavioural model of the expected bit train. Characters are looped back to the receiver in 8N1, 8E1, 8O2 and 7O1 formats, and with the address marker enabled. Running several formats separates the data-length, stop-count and parity-polarity choices, because a swapped parity sense or a miscounted bit index only shows up in some of them. A back-to-back pair followed by an extra write checks that the waiting character starts with no gap and that the write into a full holding stage is dropped. Hand-built receive frames carry a wrong parity bit and a low stop bit. The low stop bit also leaves a short low tail that the receiver must reject as a false start. Payload and ID frames sent during the wait state show that payload is discarded silently and that the first ID frame ends the wait.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  localparam int FRAME_W = 12;
  localparam int RXV_W   = 10;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;

  typedef struct packed {
    logic      len7;
    logic      stop2;
    par_mode_e par;
    logic      mp_en;
  } fmt_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [3:0]         nbits;
  } frame_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

  function automatic logic [3:0] dlen(input fmt_t f);
    return f.len7 ? 4'd7 : 4'd8;
  endfunction

  function automatic logic has_par(input fmt_t f);
    return !f.mp_en && (f.par == PAR_EVEN || f.par == PAR_ODD);
  endfunction

  function automatic logic has_ext(input fmt_t f);
    return f.mp_en || has_par(f);
  endfunction

  // bit that makes the ones count even (even mode) or odd (odd mode)
  function automatic logic par_bit(input logic [7:0] d, input fmt_t f);
    logic [7:0] m;
    m = f.len7 ? {1'b0, d[6:0]} : d;
    return (^m) ^ (f.par == PAR_ODD);
  endfunction

  // index of the first stop bit counted from the first data bit
  function automatic logic [3:0] rx_last(input fmt_t f);
    return dlen(f) + {3'b000, has_ext(f)};
  endfunction

  function automatic frame_t build_frame(input logic [7:0] d, input logic mpb,
                                         input fmt_t f);
    frame_t     r;
    logic [3:0] p;
    r.bits    = '1;
    r.bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < dlen(f)) r.bits[i+1] = d[i];
    end
    p = 4'd1 + dlen(f);
    if (f.mp_en) begin
      r.bits[p] = mpb;
      p = p + 4'd1;
    end else if (has_par(f)) begin
      r.bits[p] = par_bit(d, f);
      p = p + 4'd1;
    end
    r.nbits = p + (f.stop2 ? 4'd2 : 4'd1);
    return r;
  endfunction
endpackage

// File: rtl/mpx_tx.sv
module mpx_tx
  import mpx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_mpb,
  output logic       hold_empty,
  output logic       txd
);
  localparam int CW = $clog2(OVS);

  logic [7:0]         hold_q;
  logic               hold_mpb, hold_full, busy;
  logic [FRAME_W-1:0] sh;
  logic [3:0]         bit_idx, last_idx;
  logic [CW-1:0]      tcnt;
  logic               bit_end, frame_end, load;
  frame_t             nf;

  assign bit_end   = busy && tick && (tcnt == CW'(OVS-1));
  assign frame_end = bit_end && (bit_idx == last_idx);
  assign load      = hold_full && (!busy || frame_end);
  assign nf        = build_frame(hold_q, hold_mpb, fmt);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      hold_mpb  <= 1'b0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sh        <= '1;
      bit_idx   <= '0;
      last_idx  <= '0;
      tcnt      <= '0;
    end else begin
      if (tx_wr && !hold_full) begin
        hold_q    <= tx_data;
        hold_mpb  <= tx_mpb;
        hold_full <= 1'b1;
      end
      if (load) begin
        hold_full <= 1'b0;
        sh        <= nf.bits;
        last_idx  <= nf.nbits - 4'd1;
        bit_idx   <= '0;
        tcnt      <= '0;
        busy      <= 1'b1;
      end else if (frame_end) begin
        busy <= 1'b0;
        tcnt <= '0;
      end else if (busy && tick) begin
        if (bit_end) begin
          sh      <= {1'b1, sh[FRAME_W-1:1]};
          bit_idx <= bit_idx + 4'd1;
          tcnt    <= '0;
        end else begin
          tcnt <= tcnt + CW'(1);
        end
      end
    end
  end

  assign hold_empty = !hold_full;
  assign txd        = busy ? sh[0] : 1'b1;

  // R4: a write into a full holding stage leaves it untouched
  p_wr_dropped_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && hold_full && !load) |=> $stable(hold_q) && $stable(hold_mpb));
  // R2: the line only moves on a tick or at a character boundary
  p_bit_steady_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick && !load) |=> $stable(txd));
endmodule

// File: rtl/mpx_rx.sv
module mpx_rx
  import mpx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  fmt_t       fmt,
  input  logic       rxd,
  input  logic       rx_rd,
  input  logic       err_clr,
  input  logic       mp_wait_set,
  output logic       rxd_level,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       rx_valid,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       mp_wait
);
  localparam int CW = $clog2(OVS);

  logic             s1, s2;
  rx_st_e           st;
  logic [CW-1:0]    cnt;
  logic [3:0]       ridx;
  logic [RXV_W-1:0] rsh, vec;
  logic             smp, frm_done, discard;
  logic [7:0]       got_data;
  logic             ext_bit, stop_bit, pe_now, fe_now, mpb_now;

  assign smp      = (st == RX_BITS) && tick && (cnt == CW'(OVS-1));
  assign frm_done = smp && (ridx == rx_last(fmt));

  always_comb begin
    vec       = rsh;
    vec[ridx] = s2;
  end

  assign got_data = fmt.len7 ? {1'b0, vec[6:0]} : vec[7:0];
  assign ext_bit  = vec[dlen(fmt)];
  assign stop_bit = vec[rx_last(fmt)];
  assign pe_now   = has_par(fmt) && (ext_bit != par_bit(got_data, fmt));
  assign fe_now   = !stop_bit;
  assign mpb_now  = fmt.mp_en && ext_bit;
  assign discard  = mp_wait && fmt.mp_en && !mpb_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b1;
      s2   <= 1'b1;
      st   <= RX_IDLE;
      cnt  <= '0;
      ridx <= '0;
      rsh  <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      if (tick) begin
        case (st)
          RX_IDLE: if (!s2) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: begin
            if (cnt == CW'(OVS/2-1)) begin
              cnt  <= '0;
              ridx <= '0;
              rsh  <= '0;
              st   <= s2 ? RX_IDLE : RX_BITS;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          RX_BITS: begin
            if (smp) begin
              cnt       <= '0;
              rsh[ridx] <= s2;
              ridx      <= ridx + 4'd1;
              if (frm_done) st <= RX_IDLE;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_mpb      <= 1'b0;
      rx_valid    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      mp_wait     <= 1'b0;
    end else begin
      if (rx_rd) rx_valid <= 1'b0;
      if (err_clr) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (frm_done && !discard) begin
        if (mpb_now) mp_wait <= 1'b0;
        if (rx_valid && !rx_rd) begin
          err_overrun <= 1'b1;
        end else begin
          rx_data  <= got_data;
          rx_mpb   <= mpb_now;
          rx_valid <= 1'b1;
          if (pe_now) err_parity <= 1'b1;
          if (fe_now) err_frame  <= 1'b1;
        end
      end
      if (mp_wait_set) mp_wait <= 1'b1;
    end
  end

  assign rxd_level = s2;

  // R5: a character only appears at the end of a frame
  p_valid_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_valid) |-> $past(frm_done));
  // R8: an unread character survives the next arrival
  p_overrun_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !discard && rx_valid && !rx_rd) |=> err_overrun && $stable(rx_data));
  // R9: skipped payload leaves no trace
  p_skip_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (frm_done && discard && !rx_rd && !err_clr) |=>
      $stable(rx_valid) && $stable(err_parity) && $stable(err_frame) && $stable(err_overrun));
  // R9: an ID character ends the wait state
  p_wait_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (frm_done && mp_wait && mpb_now && !mp_wait_set) |=> !mp_wait);
endmodule

// File: rtl/mpx_uart.sv
module mpx_uart
  import mpx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       cfg_len7,
  input  logic       cfg_stop2,
  input  logic [1:0] cfg_par,
  input  logic       cfg_mp_en,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       tx_mpb,
  output logic       tx_hold_empty,
  output logic       txd,
  input  logic       rxd,
  output logic       rxd_level,
  output logic [7:0] rx_data,
  output logic       rx_mpb,
  output logic       rx_valid,
  input  logic       rx_rd,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  input  logic       err_clr,
  input  logic       mp_wait_set,
  output logic       mp_wait
);
  fmt_t fmt;

  assign fmt.len7  = cfg_len7;
  assign fmt.stop2 = cfg_stop2;
  assign fmt.par   = par_mode_e'(cfg_par);
  assign fmt.mp_en = cfg_mp_en;

  mpx_tx #(.OVS(OVS)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .fmt        (fmt),
    .tx_wr      (tx_wr),
    .tx_data    (tx_data),
    .tx_mpb     (tx_mpb),
    .hold_empty (tx_hold_empty),
    .txd        (txd)
  );

  mpx_rx #(.OVS(OVS)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .fmt         (fmt),
    .rxd         (rxd),
    .rx_rd       (rx_rd),
    .err_clr     (err_clr),
    .mp_wait_set (mp_wait_set),
    .rxd_level   (rxd_level),
    .rx_data     (rx_data),
    .rx_mpb      (rx_mpb),
    .rx_valid    (rx_valid),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .mp_wait     (mp_wait)
  );
endmodule

// File: tb/mpx_uart_bench.sv
module mpx_uart_bench;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic cfg_len7 = 1'b0, cfg_stop2 = 1'b0, cfg_mp_en = 1'b0;
  logic [1:0] cfg_par = 2'd0;
  logic tx_wr = 1'b0, tx_mpb = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_hold_empty, txd, rxd, rxd_level, rx_mpb, rx_valid;
  logic [7:0] rx_data;
  logic rx_rd = 1'b0, err_clr = 1'b0, mp_wait_set = 1'b0;
  logic err_parity, err_frame, err_overrun, mp_wait;
  logic use_raw = 1'b0, raw_line = 1'b1;

  always #5 clk = ~clk;
  assign rxd = use_raw ? raw_line : txd;

  mpx_uart u_mpx_uart (
    .clk(clk), .rst(rst), .tick(tick), .cfg_len7(cfg_len7), .cfg_stop2(cfg_stop2),
    .cfg_par(cfg_par), .cfg_mp_en(cfg_mp_en), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_mpb(tx_mpb), .tx_hold_empty(tx_hold_empty), .txd(txd), .rxd(rxd),
    .rxd_level(rxd_level), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_valid(rx_valid),
    .rx_rd(rx_rd), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .err_clr(err_clr), .mp_wait_set(mp_wait_set),
    .mp_wait(mp_wait)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // expected frame bit trains, oldest first
  logic [15:0] fq_bits[$];
  int          fq_n[$];
  logic [15:0] m_bits = '1;
  int          m_n = 0, m_cnt = 0, tph = 0;
  bit          m_act = 0;
  logic        e_bit;
  logic [15:0] raw_bits = '1;
  int          raw_n = 0, raw_cnt = 0;
  bit          raw_go = 0, raw_act = 0;

  // restatement of the line format as a list of bits
  task automatic mk_frame(input logic [7:0] d, input logic m,
                          output logic [15:0] bits, output int n);
    bit q[$];
    int ones = 0;
    int dl = cfg_len7 ? 7 : 8;
    q.push_back(1'b0);
    for (int i = 0; i < dl; i++) begin
      q.push_back(d[i]);
      ones += d[i];
    end
    if (cfg_mp_en) q.push_back(m);
    else if (cfg_par == 2'd1) q.push_back(ones % 2);
    else if (cfg_par == 2'd2) q.push_back(1 - (ones % 2));
    q.push_back(1'b1);
    if (cfg_stop2) q.push_back(1'b1);
    bits = '1;
    for (int i = 0; i < q.size(); i++) bits[i] = q[i];
    n = q.size();
  endtask

  // per-clock model of the transmit line plus the raw receive-line driver
  always @(negedge clk) begin
    if (rst) begin
      m_act = 0; tick = 0; tph = 0;
    end else begin
      if (m_act && tick) m_cnt++;
      if (m_act && m_cnt == m_n * 16) begin
        m_act = 0;
        if (fq_n.size() > 0 && txd !== 1'b0) chk(0, "R4 gapless next frame", txd, 0);
      end
      if (!m_act && txd === 1'b0) begin
        if (fq_n.size() == 0) chk(0, "R4 unexpected frame on txd", 0, 1);
        else begin
          m_bits = fq_bits.pop_front();
          m_n    = fq_n.pop_front();
          m_act  = 1;
          m_cnt  = 0;
        end
      end
      e_bit = m_act ? m_bits[m_cnt/16] : 1'b1;
      chk(txd === e_bit, "R2 R3 txd bit", txd, e_bit);
      if (raw_act && tick) raw_cnt++;
      if (raw_act && raw_cnt == raw_n * 16) begin
        raw_act = 0;
        raw_line = 1'b1;
      end
      if (raw_go && !raw_act) begin
        raw_act = 1; raw_go = 0; raw_cnt = 0;
      end
      if (raw_act) raw_line = raw_bits[raw_cnt/16];
      tph++;
      tick = (tph % 2 == 0);
    end
  end

  task automatic put(input logic [7:0] d, input logic m);
    logic [15:0] b;
    int n, w;
    @(negedge clk);
    w = 0;
    while (tx_hold_empty !== 1'b1 && w < 5000) begin
      @(negedge clk);
      w++;
    end
    tx_data = d; tx_mpb = m; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    mk_frame(d, m, b, n);
    fq_bits.push_back(b);
    fq_n.push_back(n);
  endtask

  task automatic wait_rx(input int lim, output bit got);
    got = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (rx_valid) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic do_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    chk(rx_valid == 1'b0, "R5 read clears rx_valid", rx_valid, 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic settle();
    repeat (400) @(negedge clk);
  endtask

  task automatic loop_one(input logic [7:0] d, input logic m, input string req);
    bit got;
    logic [7:0] ex;
    ex = cfg_len7 ? {1'b0, d[6:0]} : d;
    put(d, m);
    wait_rx(1200, got);
    chk(got, {req, " character received"}, got, 1);
    @(negedge clk);
    chk(rx_data == ex, {req, " rx_data"}, rx_data, ex);
    chk(err_parity == 0 && err_frame == 0, {req, " no error"}, {err_parity, err_frame}, 0);
    do_read();
  endtask

  task automatic raw_start(input logic [15:0] b, input int n);
    @(negedge clk);
    raw_bits = b; raw_n = n; raw_go = 1;
  endtask

  task automatic raw_wait();
    int w = 0;
    while ((raw_go || raw_act) && w < 5000) begin
      @(negedge clk);
      w++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    logic [15:0] b;
    int n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1 && tx_hold_empty == 1, "R1 tx idle", {txd, tx_hold_empty}, 3);
    chk(rx_valid == 0 && mp_wait == 0, "R1 rx idle", {rx_valid, mp_wait}, 0);
    chk({err_parity, err_frame, err_overrun} == 0, "R1 flags clear",
        {err_parity, err_frame, err_overrun}, 0);
    chk(rxd_level == 1, "R1 line level", rxd_level, 1);

    // R2 R5 8N1
    loop_one(8'hA5, 0, "R5 8N1");
    loop_one(8'h3C, 0, "R2 8N1");
    settle();
    // R3 8E1 and 8O2
    cfg_par = 2'd1;
    loop_one(8'h5B, 0, "R3 8E1");
    settle();
    cfg_par = 2'd2; cfg_stop2 = 1;
    loop_one(8'h5B, 0, "R3 8O2");
    settle();
    // R10 7O1
    cfg_stop2 = 0; cfg_len7 = 1;
    loop_one(8'hFF, 0, "R10 7O1");
    settle();
    cfg_len7 = 0; cfg_par = 2'd3;
    loop_one(8'h81, 0, "R3 code3 no parity");
    settle();
    cfg_par = 2'd0;

    // R4 back-to-back and dropped write
    put(8'h12, 0);
    put(8'h34, 0);
    @(negedge clk);
    chk(tx_hold_empty == 0, "R4 hold full", tx_hold_empty, 0);
    tx_data = 8'hEE; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
    wait_rx(1200, got);
    @(negedge clk);
    chk(got && rx_data == 8'h12, "R4 first of pair", rx_data, 8'h12);
    do_read();
    wait_rx(1200, got);
    @(negedge clk);
    chk(got && rx_data == 8'h34, "R4 second of pair", rx_data, 8'h34);
    do_read();
    wait_rx(1200, got);
    chk(!got, "R4 dropped write not sent", got, 0);
    settle();

    // R8 overrun
    put(8'h81, 0);
    wait_rx(1200, got);
    put(8'h7E, 0);
    repeat (900) @(negedge clk);
    chk(err_overrun == 1, "R8 overrun flag", err_overrun, 1);
    chk(rx_data == 8'h81, "R8 unread kept", rx_data, 8'h81);
    pulse_clr();
    chk(err_overrun == 0, "R11 overrun cleared", err_overrun, 0);
    do_read();
    settle();

    // R9 ID-wait
    cfg_mp_en = 1;
    @(negedge clk); mp_wait_set = 1'b1;
    @(negedge clk); mp_wait_set = 1'b0;
    chk(mp_wait == 1, "R9 wait set", mp_wait, 1);
    put(8'h11, 0);
    wait_rx(1000, got);
    chk(!got, "R9 payload skipped", got, 0);
    chk({err_parity, err_frame, err_overrun} == 0, "R9 no flags on skip",
        {err_parity, err_frame, err_overrun}, 0);
    chk(mp_wait == 1, "R9 still waiting", mp_wait, 1);
    put(8'h42, 1);
    wait_rx(1200, got);
    @(negedge clk);
    chk(got && rx_data == 8'h42 && rx_mpb == 1, "R9 ID delivered", {rx_mpb, rx_data}, 9'h142);
    chk(mp_wait == 0, "R9 wait cleared", mp_wait, 0);
    do_read();
    put(8'h33, 0);
    wait_rx(1200, got);
    @(negedge clk);
    chk(got && rx_data == 8'h33 && rx_mpb == 0, "R9 payload after ID", {rx_mpb, rx_data}, 9'h033);
    do_read();
    settle();
    cfg_mp_en = 0;

    // R6 parity error on a hand-built 8E1 frame
    cfg_par = 2'd1; use_raw = 1'b1;
    mk_frame(8'h6D, 0, b, n);
    b[9] = ~b[9];
    raw_start(b, n);
    raw_wait();
    repeat (20) @(negedge clk);
    chk(rx_valid == 1 && rx_data == 8'h6D, "R6 character kept", rx_data, 8'h6D);
    chk(err_parity == 1 && err_frame == 0, "R6 parity flag", {err_parity, err_frame}, 2);
    pulse_clr();
    chk(err_parity == 0, "R11 parity cleared", err_parity, 0);
    do_read();

    // R7 framing error with low stop bit, short low tail rejected per R5
    mk_frame(8'h0F, 0, b, n);
    b[10] = 1'b0;
    raw_start(b, n);
    wait_rx(1200, got);
    chk(got && err_frame == 1, "R7 frame flag", err_frame, 1);
    chk(rxd_level == 0, "R7 line level low", rxd_level, 0);
    raw_wait();
    repeat (100) @(negedge clk);
    chk(rxd_level == 1, "R7 line level high", rxd_level, 1);
    chk(err_overrun == 0, "R5 low tail rejected", err_overrun, 0);
    pulse_clr();
    chk(err_frame == 0, "R11 frame cleared", err_frame, 0);
    do_read();
    use_raw = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule